// File: doc/BRIEF.md
# SDRAM Burst Sequencer with Read Interruption

This block is the device-side sequencer that sits between the decoded command inputs of a four-bank synchronous DRAM and its storage array. Each clock it takes a command (no-op, activate, read or write), a bank number, a column and a data mask bit. It keeps a record of which banks have been opened. It turns each accepted read or write into a stream of column addresses toward the array, and it drives read words onto the data pins after the programmed CAS latency.

A new read or write that targets an open bank takes over at once, even while an earlier read burst is still running. The new burst starts at its own column. An interrupting write also switches the data drivers off from the next clock and throws away any read words still in flight. The mask bit gates read data two clocks later and write data in the same clock.

The storage array, refresh, precharge timing and mode programming are outside this block. Latency and burst length arrive as plain inputs. The array returns read data in the same cycle as the address it is given.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset no bank is open, and `dq_oe`, `arr_re`, `arr_we` and `cmd_err` are all low.
- R2: Command codes are no-op 2'b00, activate 2'b01, read 2'b10 and write 2'b11. An activate opens the addressed bank. A read or write to a bank that has not been opened is ignored: the running burst, the array strobes and the data output carry on unchanged, and `cmd_err` is high for the one clock after the command.
- R3: With `cas_lat` equal to 3 the first read word is driven on `dq_out` with `dq_oe` high during the third clock after the read is sampled. Any other `cas_lat` value selects latency 2, where that word is driven during the second clock.
- R4: `burst_code` 0, 1, 2 and 3 selects bursts of 1, 2, 4 and 8 words. A burst starts at the given column and counts up by one, wrapping within the block of burst-length columns that holds the start column. After its last word `dq_oe` drops in the next clock.
- R5: A read or write to any open bank, even one clock after a previous read, loads the burst engine at its own bank and column in the next clock. For a read-after-read, words of the old burst not yet fetched are dropped. The new burst's data follows the words already fetched, with no idle gap.
- R6: Write beat i stores the `dq_in` value sampled together with that beat. The first beat uses the data sampled with the write command. A high `dqm` sampled with a write beat suppresses `arr_we` for that beat only.
- R7: A write accepted while read data is pending forces `dq_oe` low from the next clock on and discards every remaining read word.
- R8: A high `dqm` sampled at a clock forces `dq_oe` low for the read word driven two clocks later. Neighbouring words are not affected.
- R9: `arr_re` and `arr_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Decoded command: 00 no-op, 01 activate, 10 read, 11 write |
| bank | input | 2 | Bank number for the command |
| col | input | COL_W | Start column for read or write |
| dqm | input | 1 | Data mask: read mask with two-clock latency, write mask with zero latency |
| dq_in | input | DQ_W | Write data from the data pins |
| cas_lat | input | 2 | CAS latency, 3 or (any other value) 2 |
| burst_code | input | 2 | Burst length code, length = 2^code |
| arr_rdata | input | DQ_W | Read word returned by the array for the current address |
| arr_bank | output | 2 | Bank of the current array access |
| arr_col | output | COL_W | Column of the current array access |
| arr_re | output | 1 | Array read strobe |
| arr_we | output | 1 | Array write strobe, already masked |
| arr_wdata | output | DQ_W | Array write data |
| dq_out | output | DQ_W | Read data toward the pins, zero when not driven |
| dq_oe | output | 1 | Output enable for the data pins |
| cmd_err | output | 1 | Pulse for a read or write to a bank that is not open |

## Verification
Plain bursts run at both latencies and at all four lengths from unaligned columns. The wrap order shows whether the column counter stays inside its aligned block, and the idle clock before the first word shows which latency tap is used. A read one clock after another read tells the drop-and-continue rule apart from a flush or a completed old burst. A write two clocks after a read shows both the driver cut-off and the write data capture with a masked beat. A mask pulse in the middle of a read shows the two-clock mask delay, and reads and writes to a closed bank during a live burst show that such commands leave everything untouched.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } sdb_cmd_e;

  // index of the final beat in a burst: code 0..3 -> 0,1,3,7
  function automatic logic [2:0] last_beat_idx(input logic [1:0] code);
    logic [3:0] words;
    words = 4'd1 << code;
    return 3'(words - 4'd1);
  endfunction

  // next column inside the aligned block of 2^code columns
  function automatic logic [15:0] wrap_col(input logic [15:0] c, input logic [1:0] code);
    logic [15:0] m;
    m = (16'd1 << code) - 16'd1;
    return (c & ~m) | ((c + 16'd1) & m);
  endfunction

  // pipeline tap for a latency setting; latency 2 uses stage 0
  function automatic int lat_tap(input logic [1:0] cl, input int max_cl);
    int t;
    if (cl == 2'd3) t = 1;
    else            t = 0;
    if (t > max_cl - 2) t = max_cl - 2;
    return t;
  endfunction

endpackage

// File: rtl/sdb_bank_table.sv
module sdb_bank_table #(
  parameter int BANKS = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic [BA_W-1:0]  act_bank,
  output logic [BANKS-1:0] open_vec
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        open_vec[b] <= 1'b0;
      else if (act_en && (act_bank == BA_W'(b)))
        open_vec[b] <= 1'b1;
    end
  end

endmodule

// File: rtl/sdb_burst_gen.sv
module sdb_burst_gen
  import sdb_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int BA_W  = 2,
  parameter int DQ_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_wr,
  input  logic [BA_W-1:0]  load_bank,
  input  logic [COL_W-1:0] load_col,
  input  logic [1:0]       burst_code,
  input  logic [DQ_W-1:0]  dq_in,
  input  logic             dqm,
  output logic             beat_vld,
  output logic             beat_wr,
  output logic [BA_W-1:0]  beat_bank,
  output logic [COL_W-1:0] beat_col,
  output logic [DQ_W-1:0]  wdata_q,
  output logic             wmask_q
);

  logic [2:0]       left_q;
  logic [1:0]       code_q;
  logic [COL_W-1:0] col_next;

  assign col_next = COL_W'(wrap_col(16'(beat_col), code_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_vld  <= 1'b0;
      beat_wr   <= 1'b0;
      beat_bank <= '0;
      beat_col  <= '0;
      left_q    <= '0;
      code_q    <= '0;
    end else if (load) begin
      beat_vld  <= 1'b1;
      beat_wr   <= load_wr;
      beat_bank <= load_bank;
      beat_col  <= load_col;
      left_q    <= last_beat_idx(burst_code);
      code_q    <= burst_code;
    end else if (beat_vld) begin
      if (left_q == 3'd0) begin
        beat_vld <= 1'b0;
      end else begin
        beat_col <= col_next;
        left_q   <= left_q - 3'd1;
      end
    end
  end

  // write data and mask travel with the beat they were sampled for
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q <= '0;
      wmask_q <= 1'b0;
    end else begin
      wdata_q <= dq_in;
      wmask_q <= dqm;
    end
  end

endmodule

// File: rtl/sdb_read_pipe.sv
module sdb_read_pipe
  import sdb_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int MAX_CL = 3,
  localparam int DEPTH = MAX_CL - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_vld,
  input  logic [DQ_W-1:0] cap_data,
  input  logic            flush,
  input  logic            dqm,
  input  logic [1:0]      cas_lat,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe
);

  logic [DEPTH-1:0] stg_vld;
  logic [DQ_W-1:0]  stg_dat [DEPTH];
  logic             dqm_d1, dqm_d2;
  logic             sel_vld;
  logic [DQ_W-1:0]  sel_dat;
  int               tap;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_vld[k] <= 1'b0;
        stg_dat[k] <= '0;
      end else begin
        if (k == 0) begin
          stg_vld[k] <= cap_vld && !flush;
          stg_dat[k] <= cap_data;
        end else begin
          stg_vld[k] <= stg_vld[(k > 0) ? k - 1 : 0] && !flush;
          stg_dat[k] <= stg_dat[(k > 0) ? k - 1 : 0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dqm_d1 <= 1'b0;
      dqm_d2 <= 1'b0;
    end else begin
      dqm_d1 <= dqm;
      dqm_d2 <= dqm_d1;
    end
  end

  assign tap = lat_tap(cas_lat, MAX_CL);

  always_comb begin
    sel_vld = 1'b0;
    sel_dat = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k == tap) begin
        sel_vld = stg_vld[k];
        sel_dat = stg_dat[k];
      end
    end
  end

  assign dq_oe  = sel_vld && !dqm_d2;
  assign dq_out = dq_oe ? sel_dat : '0;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdb_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int DQ_W   = 16,
  parameter int BANKS  = 4,
  parameter int MAX_CL = 3,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [BA_W-1:0]  bank,
  input  logic [COL_W-1:0] col,
  input  logic             dqm,
  input  logic [DQ_W-1:0]  dq_in,
  input  logic [1:0]       cas_lat,
  input  logic [1:0]       burst_code,
  input  logic [DQ_W-1:0]  arr_rdata,
  output logic [BA_W-1:0]  arr_bank,
  output logic [COL_W-1:0] arr_col,
  output logic             arr_re,
  output logic             arr_we,
  output logic [DQ_W-1:0]  arr_wdata,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  output logic             cmd_err
);

  // named internal events, used by the checker
  logic [BANKS-1:0] bank_open;
  logic             is_rw;
  logic             accept;
  logic             wr_accept;
  logic             bad_cmd;
  logic             beat_vld, beat_wr, wmask_q;

  assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign accept    = is_rw && bank_open[bank];
  assign bad_cmd   = is_rw && !bank_open[bank];
  assign wr_accept = accept && (cmd == CMD_WR);

  sdb_bank_table #(.BANKS(BANKS)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_en   (cmd == CMD_ACT),
    .act_bank (bank),
    .open_vec (bank_open)
  );

  sdb_burst_gen #(.COL_W(COL_W), .BA_W(BA_W), .DQ_W(DQ_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_wr    (cmd == CMD_WR),
    .load_bank  (bank),
    .load_col   (col),
    .burst_code (burst_code),
    .dq_in      (dq_in),
    .dqm        (dqm),
    .beat_vld   (beat_vld),
    .beat_wr    (beat_wr),
    .beat_bank  (arr_bank),
    .beat_col   (arr_col),
    .wdata_q    (arr_wdata),
    .wmask_q    (wmask_q)
  );

  assign arr_re = beat_vld && !beat_wr;
  assign arr_we = beat_vld && beat_wr && !wmask_q;

  sdb_read_pipe #(.DQ_W(DQ_W), .MAX_CL(MAX_CL)) u_rpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_vld  (arr_re),
    .cap_data (arr_rdata),
    .flush    (wr_accept),
    .dqm      (dqm),
    .cas_lat  (cas_lat),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= bad_cmd;
  end

endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int COL_W = 8,
  parameter int BANKS = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic [BA_W-1:0]  bank,
  input logic [COL_W-1:0] col,
  input logic             dqm,
  input logic [BA_W-1:0]  arr_bank,
  input logic [COL_W-1:0] arr_col,
  input logic             arr_re,
  input logic             arr_we,
  input logic             dq_oe,
  input logic             cmd_err,
  input logic [BANKS-1:0] bank_open,
  input logic             accept,
  input logic             wr_accept
);

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dq_oe && !arr_re && !arr_we && !cmd_err)); // R1

  AST_CLOSED_BANK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[1] && !bank_open[bank]) |=> cmd_err); // R2

  AST_LOAD_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (arr_col == $past(col) && arr_bank == $past(bank))); // R5

  AST_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && arr_we) |-> !$past(dqm)); // R6

  AST_WRITE_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !dq_oe); // R7

  AST_READ_DQM: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(dqm, 2)) |-> !dq_oe); // R8

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_re && arr_we)); // R9

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W), .BANKS(BANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       (cmd),
  .bank      (bank),
  .col       (col),
  .dqm       (dqm),
  .arr_bank  (arr_bank),
  .arr_col   (arr_col),
  .arr_re    (arr_re),
  .arr_we    (arr_we),
  .dq_oe     (dq_oe),
  .cmd_err   (cmd_err),
  .bank_open (bank_open),
  .accept    (accept),
  .wr_accept (wr_accept)
);

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_NOP = 2'b00, C_ACT = 2'b01, C_RD = 2'b10, C_WR = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = C_NOP;
  logic [1:0]  bank = '0;
  logic [7:0]  col = '0;
  logic        dqm = 1'b0;
  logic [15:0] dq_in = '0;
  logic [1:0]  cas_lat = 2'd2;
  logic [1:0]  burst_code = 2'd2;
  logic [15:0] arr_rdata;
  logic [1:0]  arr_bank;
  logic [7:0]  arr_col;
  logic        arr_re, arr_we;
  logic [15:0] arr_wdata, dq_out;
  logic        dq_oe, cmd_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(input logic [1:0] b, input logic [7:0] c);
    return {6'h15, b, c};
  endfunction

  assign arr_rdata = pat(arr_bank, arr_col);

  sdram_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .col(col), .dqm(dqm),
    .dq_in(dq_in), .cas_lat(cas_lat), .burst_code(burst_code), .arr_rdata(arr_rdata),
    .arr_bank(arr_bank), .arr_col(arr_col), .arr_re(arr_re), .arr_we(arr_we),
    .arr_wdata(arr_wdata), .dq_out(dq_out), .dq_oe(dq_oe), .cmd_err(cmd_err)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] c, input logic [1:0] b, input logic [7:0] cl);
    cmd = c; bank = b; col = cl;
  endtask

  task automatic expect_word(input string req, input logic [1:0] b, input logic [7:0] c);
    check(req, "dq_oe", 32'(dq_oe), 32'd1);
    check(req, "dq_out", 32'(dq_out), 32'(pat(b, c)));
  endtask

  task automatic expect_off(input string req);
    check(req, "dq_oe off", 32'(dq_oe), 32'd0);
  endtask

  task automatic settle();
    drive(C_NOP, 2'd0, 8'd0);
    dqm = 1'b0;
    repeat (12) tick();
  endtask

  task automatic test_reset();
    check("R1", "dq_oe", 32'(dq_oe), 32'd0);
    check("R1", "arr_re", 32'(arr_re), 32'd0);
    check("R1", "arr_we", 32'(arr_we), 32'd0);
    check("R1", "cmd_err", 32'(cmd_err), 32'd0);
  endtask

  task automatic open_bank(input logic [1:0] b);
    drive(C_ACT, b, 8'd0); tick();
    drive(C_NOP, 2'd0, 8'd0); tick();
  endtask

  // R2: commands to a closed bank during a live read are ignored
  task automatic test_closed_bank();
    cas_lat = 2'd2; burst_code = 2'd2;
    drive(C_RD, 2'd0, 8'h00); tick();
    drive(C_RD, 2'd3, 8'h40); tick();
    check("R2", "cmd_err after read", 32'(cmd_err), 32'd1);
    check("R2", "arr_col kept", 32'(arr_col), 32'h01);
    check("R2", "arr_bank kept", 32'(arr_bank), 32'd0);
    expect_word("R2", 2'd0, 8'h00);
    drive(C_WR, 2'd3, 8'h41); dq_in = 16'hDEAD; tick();
    check("R2", "cmd_err after write", 32'(cmd_err), 32'd1);
    check("R2", "no array write", 32'(arr_we), 32'd0);
    expect_word("R2", 2'd0, 8'h01);
    drive(C_NOP, 2'd0, 8'd0); tick();
    check("R2", "cmd_err clears", 32'(cmd_err), 32'd0);
    expect_word("R2", 2'd0, 8'h02);
    tick(); expect_word("R2", 2'd0, 8'h03);
    tick(); expect_off("R4");
    settle();
  endtask

  // R3 R4: latency 2, length 4, unaligned start
  task automatic test_read_cl2_bl4();
    cas_lat = 2'd2; burst_code = 2'd2;
    drive(C_RD, 2'd1, 8'h06); tick();
    drive(C_NOP, 2'd0, 8'd0);
    check("R4", "first column", 32'(arr_col), 32'h06);
    check("R4", "arr_re", 32'(arr_re), 32'd1);
    expect_off("R3");
    tick(); expect_word("R3", 2'd1, 8'h06);
    tick(); expect_word("R4", 2'd1, 8'h07);
    tick(); expect_word("R4", 2'd1, 8'h04);
    tick(); expect_word("R4", 2'd1, 8'h05);
    tick(); expect_off("R4");
    settle();
  endtask

  // R3 R4: latency 3, length 8
  task automatic test_read_cl3_bl8();
    cas_lat = 2'd3; burst_code = 2'd3;
    drive(C_RD, 2'd2, 8'h1D); tick();
    drive(C_NOP, 2'd0, 8'd0);
    tick(); expect_off("R3");
    tick(); expect_word("R3", 2'd2, 8'h1D);
    tick(); expect_word("R4", 2'd2, 8'h1E);
    tick(); expect_word("R4", 2'd2, 8'h1F);
    for (int i = 0; i < 5; i++) begin
      tick(); expect_word("R4", 2'd2, 8'(8'h18 + i));
    end
    tick(); expect_off("R4");
    settle();
  endtask

  // R4: short bursts
  task automatic test_short_bursts();
    cas_lat = 2'd2; burst_code = 2'd1;
    drive(C_RD, 2'd1, 8'h03); tick();
    drive(C_NOP, 2'd0, 8'd0);
    tick(); expect_word("R4", 2'd1, 8'h03);
    tick(); expect_word("R4", 2'd1, 8'h02);
    tick(); expect_off("R4");
    settle();
    burst_code = 2'd0;
    drive(C_RD, 2'd2, 8'h05); tick();
    drive(C_NOP, 2'd0, 8'd0);
    tick(); expect_word("R4", 2'd2, 8'h05);
    tick(); expect_off("R4");
    settle();
  endtask

  // R5: read interrupted by read one clock later
  task automatic test_read_read();
    cas_lat = 2'd2; burst_code = 2'd2;
    drive(C_RD, 2'd0, 8'h10); tick();
    check("R5", "old column", 32'(arr_col), 32'h10);
    drive(C_RD, 2'd2, 8'h23); tick();
    drive(C_NOP, 2'd0, 8'd0);
    check("R5", "new column", 32'(arr_col), 32'h23);
    check("R5", "new bank", 32'(arr_bank), 32'd2);
    expect_word("R5", 2'd0, 8'h10);
    tick(); expect_word("R5", 2'd2, 8'h23);
    tick(); expect_word("R5", 2'd2, 8'h20);
    tick(); expect_word("R5", 2'd2, 8'h21);
    tick(); expect_word("R5", 2'd2, 8'h22);
    tick(); expect_off("R5");
    settle();
  endtask

  // R6 R7: read interrupted by write, one write beat masked
  task automatic test_read_write();
    cas_lat = 2'd2; burst_code = 2'd2;
    drive(C_RD, 2'd0, 8'h00); tick();
    drive(C_NOP, 2'd0, 8'd0); tick();
    expect_word("R7", 2'd0, 8'h00);
    drive(C_WR, 2'd3, 8'h09); dq_in = 16'hA000; tick();
    drive(C_NOP, 2'd0, 8'd0); dq_in = 16'hA001; dqm = 1'b1;
    expect_off("R7");
    check("R6", "arr_we beat0", 32'(arr_we), 32'd1);
    check("R6", "col beat0", 32'(arr_col), 32'h09);
    check("R6", "wdata beat0", 32'(arr_wdata), 32'hA000);
    check("R9", "no read strobe", 32'(arr_re), 32'd0);
    tick();
    dq_in = 16'hA002; dqm = 1'b0;
    check("R6", "masked beat1", 32'(arr_we), 32'd0);
    check("R6", "col beat1", 32'(arr_col), 32'h0A);
    expect_off("R7");
    tick();
    dq_in = 16'hA003;
    check("R6", "arr_we beat2", 32'(arr_we), 32'd1);
    check("R6", "wdata beat2", 32'(arr_wdata), 32'hA002);
    check("R6", "col beat2", 32'(arr_col), 32'h0B);
    expect_off("R7");
    tick();
    check("R6", "wdata beat3", 32'(arr_wdata), 32'hA003);
    check("R6", "col wraps", 32'(arr_col), 32'h08);
    expect_off("R7");
    tick();
    check("R6", "burst done", 32'(arr_we), 32'd0);
    settle();
  endtask

  // R8: read mask two clocks later
  task automatic test_read_dqm();
    cas_lat = 2'd2; burst_code = 2'd2;
    drive(C_RD, 2'd1, 8'h30); tick();
    drive(C_NOP, 2'd0, 8'd0); dqm = 1'b1; tick();
    dqm = 1'b0;
    expect_word("R8", 2'd1, 8'h30);
    tick(); expect_off("R8");
    tick(); expect_word("R8", 2'd1, 8'h32);
    tick(); expect_word("R8", 2'd1, 8'h33);
    settle();
  endtask

  initial begin
    repeat (4) tick();
    test_reset();
    rst_n = 1'b1;
    tick();
    test_reset();
    open_bank(2'd0); open_bank(2'd1); open_bank(2'd2);
    test_closed_bank();
    open_bank(2'd3);
    test_read_cl2_bl4();
    test_read_cl3_bl8();
    test_short_bursts();
    test_read_read();
    test_read_write();
    test_read_dqm();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule